// File: doc/BRIEF.md
# IQ DC Offset Calibration Controller

This block cancels the DC error carried by the in-phase and quadrature sample streams of a baseband receiver before those samples reach the output stage. Each channel keeps a 10-bit signed correction. The correction is scaled into the 15-bit sample format and subtracted from every sample. The result is clipped to the 15-bit signed range.

The correction can come from two places, chosen by a mode input. In automatic mode the block calibrates itself each time the receive path leaves sleep. It asserts an input-short control and averages 16 sample pairs taken with the inputs shorted. It stores the averages and then releases the inputs. In user mode a host loads the corrections directly, and they survive sleep. In both modes the output strobe stays low after wake until a parameterised number of sample periods has passed, so that analog and filter settling is not seen downstream.

Top module: `iq_dcoc_ctrl`

## Requirements
- R1: After reset, `out_valid_o`, `cal_busy_o` and `short_o` are low and both offset registers read 0.
- R2: For each sample taken in the running state, the output equals the sample minus the offset placed at bits 11..2 of a 15-bit word, with bits 1..0 zero and bits 14..12 sign-extended. This equals sample − 4·offset, where both values are two's complement. The result appears on the cycle after the sample strobe, and `out_valid_o` is high for that one cycle.
- R3: The subtraction result is clipped to the range −16384..16383 rather than wrapping.
- R4: With `user_mode_i` = 0, a wake from sleep (`sleep_i` falling to 0) raises `cal_busy_o` and `short_o` from the next cycle. The block then takes 16 strobed samples per channel and stores floor(sum/64) as the channel offset. Both flags drop on the cycle the result is stored.
- R5: The stored automatic result is saturated to the 10-bit range −512..511.
- R6: With `user_mode_i` = 1, a cycle with `wr_en_i` high loads `wr_data_i` into the I offset when `wr_sel_i` = 0, or into the Q offset when `wr_sel_i` = 1. The new value is visible on the next cycle.
- R7: With `user_mode_i` = 0, a host write leaves both offset registers unchanged.
- R8: With `user_mode_i` = 1 at wake, no calibration runs, `cal_busy_o` stays low, and the offsets written before sleep are kept.
- R9: After wake, `out_valid_o` stays low for the first `SETTLE_SMP` samples. These are counted after the stored calibration in automatic mode, or from wake in user mode. The next sample is the first one output.
- R10: While `sleep_i` is high, `cal_busy_o` and `short_o` are low and no sample is output. A calibration that sleep interrupts stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | 1 = receive path in low-power sleep |
| user_mode_i | input | 1 | 0 = automatic calibration, 1 = host-loaded offsets |
| smp_valid_i | input | 1 | Sample-pair strobe |
| smp_i_i | input | 15 | I sample, two's complement |
| smp_q_i | input | 15 | Q sample, two's complement |
| wr_en_i | input | 1 | Host offset write strobe |
| wr_sel_i | input | 1 | Write target: 0 = I, 1 = Q |
| wr_data_i | input | 10 | Offset value to write, two's complement |
| short_o | output | 1 | Disconnect and short the receive inputs |
| cal_busy_o | output | 1 | Automatic calibration in progress |
| out_valid_o | output | 1 | Corrected sample pair valid |
| out_i_o | output | 15 | Corrected I sample |
| out_q_o | output | 15 | Corrected Q sample |
| ofs_i_o | output | 10 | Current I offset register |
| ofs_q_o | output | 10 | Current Q offset register |

## Verification
Some properties are checked on every cycle. The output strobe is never high during calibration and only follows a sample taken in the running state. Sleep clears the busy flag on the next cycle. The settle counter stays within its bound. Offsets do not move in automatic mode except when a calibration result is stored. The bench scenarios are needed for the numbers themselves: the averaged and saturated offset values, the clipped subtraction results, the exact sample on which output resumes after wake in each mode, and the keeping of host offsets across sleep.

// File: rtl/iq_dcoc_pkg.sv
package iq_dcoc_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP  = 2'd0,
    ST_CAL    = 2'd1,
    ST_SETTLE = 2'd2,
    ST_RUN    = 2'd3
  } dcoc_state_e;

  localparam int unsigned DEF_SMP_W      = 15;
  localparam int unsigned DEF_OFS_W      = 10;
  localparam int unsigned DEF_OFS_LSB    = 2;
  localparam int unsigned DEF_AVG_LOG2   = 4;
  localparam int unsigned DEF_SETTLE_SMP = 8;

endpackage

// File: rtl/dcoc_seq.sv
module dcoc_seq
  import iq_dcoc_pkg::*;
#(
  parameter int unsigned AVG_LOG2   = DEF_AVG_LOG2,
  parameter int unsigned SETTLE_SMP = DEF_SETTLE_SMP
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sleep_i,
  input  logic        user_mode_i,
  input  logic        smp_valid_i,
  output dcoc_state_e state_o,
  output logic        acc_clr_o,
  output logic        acc_en_o,
  output logic        cal_last_o,
  output logic        busy_o
);

  localparam int unsigned AVG_N   = 1 << AVG_LOG2;
  localparam int unsigned CNT_MAX = (AVG_N > SETTLE_SMP) ? AVG_N : SETTLE_SMP;
  localparam int unsigned CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
  localparam logic [CNT_W-1:0] AVG_LAST    = CNT_W'(AVG_N - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_SMP - 1);

  dcoc_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cal_last;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    cal_last = 1'b0;
    case (state_q)
      ST_SLEEP: begin
        cnt_d = '0;
        if (!sleep_i) state_d = user_mode_i ? ST_SETTLE : ST_CAL;
      end
      ST_CAL: begin
        if (smp_valid_i) begin
          if (cnt_q == AVG_LAST) begin
            state_d  = ST_SETTLE;
            cnt_d    = '0;
            cal_last = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_SETTLE: begin
        if (smp_valid_i) begin
          if (cnt_q == SETTLE_LAST) begin
            state_d = ST_RUN;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: ;
    endcase
    if (sleep_i) begin
      state_d  = ST_SLEEP;
      cnt_d    = '0;
      cal_last = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SLEEP;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o    = state_q;
  assign acc_clr_o  = (state_q == ST_SLEEP);
  assign acc_en_o   = (state_q == ST_CAL) && smp_valid_i && !sleep_i;
  assign cal_last_o = cal_last;
  assign busy_o     = (state_q == ST_CAL);

  // R10: sleep request drops calibration on the next cycle
  assert_busy_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> !busy_o);

  // R9: settle count never passes its window
  assert_settle_cnt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE) |-> (cnt_q <= SETTLE_LAST));

endmodule

// File: rtl/dcoc_chan.sv
module dcoc_chan
  import iq_dcoc_pkg::*;
#(
  parameter int unsigned SMP_W    = DEF_SMP_W,
  parameter int unsigned OFS_W    = DEF_OFS_W,
  parameter int unsigned OFS_LSB  = DEF_OFS_LSB,
  parameter int unsigned AVG_LOG2 = DEF_AVG_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             acc_clr_i,
  input  logic             acc_en_i,
  input  logic             cal_last_i,
  input  logic             wr_en_i,
  input  logic [OFS_W-1:0] wr_data_i,
  input  logic             run_smp_i,
  output logic [OFS_W-1:0] ofs_o,
  output logic [SMP_W-1:0] out_o
);

  localparam int unsigned ACC_W = SMP_W + AVG_LOG2;
  localparam int unsigned SHIFT = AVG_LOG2 + OFS_LSB;
  localparam int unsigned DW    = SMP_W + 1;
  localparam int unsigned EXT_W = DW - OFS_W - OFS_LSB;
  localparam logic signed [ACC_W-1:0] LIM_HI = ACC_W'((2 ** (OFS_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] LIM_LO = ~LIM_HI;
  localparam logic [SMP_W-1:0] OUT_MAX = {1'b0, {(SMP_W-1){1'b1}}};
  localparam logic [SMP_W-1:0] OUT_MIN = {1'b1, {(SMP_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_q, acc_d, sum_nxt, avg_sh;
  logic [OFS_W-1:0]        ofs_q, ofs_d, avg_sat;
  logic signed [DW-1:0]    smp_ext, ofs_ext, diff;
  logic [SMP_W-1:0]        out_q, out_d, diff_sat;

  // accumulate and average
  always_comb begin
    sum_nxt = acc_q + $signed({{AVG_LOG2{smp_i[SMP_W-1]}}, smp_i});
    avg_sh  = sum_nxt >>> SHIFT;
    if (avg_sh > LIM_HI)      avg_sat = LIM_HI[OFS_W-1:0];
    else if (avg_sh < LIM_LO) avg_sat = LIM_LO[OFS_W-1:0];
    else                      avg_sat = avg_sh[OFS_W-1:0];
  end

  always_comb begin
    acc_d = acc_q;
    if (acc_clr_i)     acc_d = '0;
    else if (acc_en_i) acc_d = sum_nxt;
  end

  // offset register: calibration result has priority over host write
  always_comb begin
    ofs_d = ofs_q;
    if (cal_last_i)   ofs_d = avg_sat;
    else if (wr_en_i) ofs_d = wr_data_i;
  end

  // offset subtraction with clipping
  always_comb begin
    smp_ext = $signed({smp_i[SMP_W-1], smp_i});
    ofs_ext = $signed({{EXT_W{ofs_q[OFS_W-1]}}, ofs_q, {OFS_LSB{1'b0}}});
    diff    = smp_ext - ofs_ext;
    if (diff[DW-1] != diff[DW-2]) diff_sat = diff[DW-1] ? OUT_MIN : OUT_MAX;
    else                          diff_sat = diff[SMP_W-1:0];
    out_d = run_smp_i ? diff_sat : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ofs_q <= '0;
      out_q <= '0;
    end else begin
      acc_q <= acc_d;
      ofs_q <= ofs_d;
      out_q <= out_d;
    end
  end

  assign ofs_o = ofs_q;
  assign out_o = out_q;

endmodule

// File: rtl/iq_dcoc_ctrl.sv
module iq_dcoc_ctrl
  import iq_dcoc_pkg::*;
#(
  parameter int unsigned SMP_W      = DEF_SMP_W,
  parameter int unsigned OFS_W      = DEF_OFS_W,
  parameter int unsigned OFS_LSB    = DEF_OFS_LSB,
  parameter int unsigned AVG_LOG2   = DEF_AVG_LOG2,
  parameter int unsigned SETTLE_SMP = DEF_SETTLE_SMP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_i,
  input  logic             user_mode_i,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_i_i,
  input  logic [SMP_W-1:0] smp_q_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [OFS_W-1:0] wr_data_i,
  output logic             short_o,
  output logic             cal_busy_o,
  output logic             out_valid_o,
  output logic [SMP_W-1:0] out_i_o,
  output logic [SMP_W-1:0] out_q_o,
  output logic [OFS_W-1:0] ofs_i_o,
  output logic [OFS_W-1:0] ofs_q_o
);

  localparam int unsigned N_CH = 2;

  logic        rst_s1_q, rst_s2_q;
  logic        rst_sn;
  dcoc_state_e state;
  logic        acc_clr, acc_en, cal_last, busy;
  logic        run_smp;
  logic        out_valid_q, out_valid_d;

  logic [N_CH-1:0][SMP_W-1:0] ch_smp, ch_out;
  logic [N_CH-1:0][OFS_W-1:0] ch_ofs;
  logic [N_CH-1:0]            ch_wr;

  // reset: asserted asynchronously, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_sn = rst_s2_q;

  dcoc_seq #(
    .AVG_LOG2  (AVG_LOG2),
    .SETTLE_SMP(SETTLE_SMP)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sn),
    .sleep_i    (sleep_i),
    .user_mode_i(user_mode_i),
    .smp_valid_i(smp_valid_i),
    .state_o    (state),
    .acc_clr_o  (acc_clr),
    .acc_en_o   (acc_en),
    .cal_last_o (cal_last),
    .busy_o     (busy)
  );

  assign run_smp   = (state == ST_RUN) && smp_valid_i;
  assign ch_smp[0] = smp_i_i;
  assign ch_smp[1] = smp_q_i;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign ch_wr[c] = wr_en_i && user_mode_i && (wr_sel_i == c[0]);

    dcoc_chan #(
      .SMP_W   (SMP_W),
      .OFS_W   (OFS_W),
      .OFS_LSB (OFS_LSB),
      .AVG_LOG2(AVG_LOG2)
    ) u_chan (
      .clk       (clk),
      .rst_n     (rst_sn),
      .smp_i     (ch_smp[c]),
      .acc_clr_i (acc_clr),
      .acc_en_i  (acc_en),
      .cal_last_i(cal_last),
      .wr_en_i   (ch_wr[c]),
      .wr_data_i (wr_data_i),
      .run_smp_i (run_smp),
      .ofs_o     (ch_ofs[c]),
      .out_o     (ch_out[c])
    );
  end

  assign out_valid_d = run_smp;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) out_valid_q <= 1'b0;
    else         out_valid_q <= out_valid_d;
  end

  assign short_o     = busy;
  assign cal_busy_o  = busy;
  assign out_valid_o = out_valid_q;
  assign out_i_o     = ch_out[0];
  assign out_q_o     = ch_out[1];
  assign ofs_i_o     = ch_ofs[0];
  assign ofs_q_o     = ch_ofs[1];

  // R9: a corrected sample only follows a sample taken while running
  assert_valid_run_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    out_valid_o |-> $past(state == ST_RUN));

  // R4: no output while calibrating
  assert_busy_no_valid_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    cal_busy_o |-> !out_valid_o);

  // R7: offsets hold in automatic mode unless a calibration result lands
  assert_auto_wr_ignored_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (!user_mode_i && !cal_last) |=> ($stable(ofs_i_o) && $stable(ofs_q_o)));

endmodule

// File: tb/iq_dcoc_ctrl_bench.sv
module iq_dcoc_ctrl_bench;

  localparam int SETTLE = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sleep_i, user_mode_i, smp_valid_i;
  logic [14:0] smp_i_i, smp_q_i;
  logic        wr_en_i, wr_sel_i;
  logic [9:0]  wr_data_i;
  logic        short_o, cal_busy_o, out_valid_o;
  logic [14:0] out_i_o, out_q_o;
  logic [9:0]  ofs_i_o, ofs_q_o;

  int n_chk = 0;
  int n_err = 0;
  int mi = 0;
  int mq = 0;

  always #4 clk = ~clk;

  iq_dcoc_ctrl #(.SETTLE_SMP(SETTLE)) u_iq_dcoc_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .user_mode_i(user_mode_i),
    .smp_valid_i(smp_valid_i), .smp_i_i(smp_i_i), .smp_q_i(smp_q_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .short_o(short_o), .cal_busy_o(cal_busy_o), .out_valid_o(out_valid_o),
    .out_i_o(out_i_o), .out_q_o(out_q_o), .ofs_i_o(ofs_i_o), .ofs_q_o(ofs_q_o)
  );

  function automatic int sat15(int v);
    if (v > 16383) return 16383;
    if (v < -16384) return -16384;
    return v;
  endfunction

  function automatic int avg10(int s);
    int v = s >>> 6;
    if (v > 511) return 511;
    if (v < -512) return -512;
    return v;
  endfunction

  function automatic int clamp15(int v);
    return sat15(v);
  endfunction

  function automatic int rnd15();
    return int'($urandom_range(32767)) - 16384;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic smp(int i, int q);
    @(negedge clk);
    smp_valid_i = 1'b1;
    smp_i_i = i[14:0];
    smp_q_i = q[14:0];
    @(negedge clk);
    smp_valid_i = 1'b0;
  endtask

  task automatic run_smp(int i, int q, string req);
    smp(i, q);
    chk({req, " valid"}, int'(out_valid_o), 1);
    chk({req, " I"}, int'($signed(out_i_o)), sat15(i - 4 * mi));
    chk({req, " Q"}, int'($signed(out_q_o)), sat15(q - 4 * mq));
  endtask

  task automatic settle_phase();
    for (int k = 0; k < SETTLE; k++) begin
      smp(rnd15(), rnd15());
      chk("R9 settle no valid", int'(out_valid_o), 0);
    end
  endtask

  task automatic go_sleep();
    @(negedge clk);
    sleep_i = 1'b1;
    @(negedge clk);
    chk("R10 busy low in sleep", int'(cal_busy_o), 0);
    chk("R10 short low in sleep", int'(short_o), 0);
  endtask

  task automatic wake_auto(int ci, int cq, int noise);
    int si = 0;
    int sq = 0;
    user_mode_i = 1'b0;
    @(negedge clk);
    sleep_i = 1'b0;
    @(negedge clk);
    chk("R4 busy after wake", int'(cal_busy_o), 1);
    chk("R4 short after wake", int'(short_o), 1);
    for (int k = 0; k < 16; k++) begin
      int vi = clamp15(ci + int'($urandom_range(2 * noise)) - noise);
      int vq = clamp15(cq + int'($urandom_range(2 * noise)) - noise);
      si += vi;
      sq += vq;
      smp(vi, vq);
      chk("R4 no valid during cal", int'(out_valid_o), 0);
      if (k < 15) chk("R4 busy during cal", int'(cal_busy_o), 1);
    end
    mi = avg10(si);
    mq = avg10(sq);
    chk("R4 busy drops", int'(cal_busy_o), 0);
    chk("R4/R5 I offset stored", int'($signed(ofs_i_o)), mi);
    chk("R4/R5 Q offset stored", int'($signed(ofs_q_o)), mq);
  endtask

  task automatic host_wr(bit sel, int v);
    @(negedge clk);
    wr_en_i = 1'b1;
    wr_sel_i = sel;
    wr_data_i = v[9:0];
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0; sleep_i = 1'b1; user_mode_i = 1'b0; smp_valid_i = 1'b0;
    smp_i_i = '0; smp_q_i = '0; wr_en_i = 1'b0; wr_sel_i = 1'b0; wr_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 out_valid", int'(out_valid_o), 0);
    chk("R1 busy", int'(cal_busy_o), 0);
    chk("R1 short", int'(short_o), 0);
    chk("R1 ofs I", int'(ofs_i_o), 0);
    chk("R1 ofs Q", int'(ofs_q_o), 0);

    // automatic calibration, moderate offsets
    wake_auto(1200, -900, 40);
    settle_phase();
    for (int k = 0; k < 20; k++) run_smp(rnd15(), rnd15(), "R2 random");

    // R7: host write ignored in automatic mode
    host_wr(1'b0, 300);
    chk("R7 I offset kept", int'($signed(ofs_i_o)), mi);
    host_wr(1'b1, -77);
    chk("R7 Q offset kept", int'($signed(ofs_q_o)), mq);
    run_smp(5000, -5000, "R7 output uses old offset");

    // R10: sleep stops output
    go_sleep();
    smp(1000, 1000);
    chk("R10 no output in sleep", int'(out_valid_o), 0);

    // R10: sleep interrupts calibration; nothing stored
    user_mode_i = 1'b0;
    @(negedge clk);
    sleep_i = 1'b0;
    for (int k = 0; k < 5; k++) smp(16000, -16000);
    go_sleep();
    chk("R10 aborted cal I kept", int'($signed(ofs_i_o)), mi);
    chk("R10 aborted cal Q kept", int'($signed(ofs_q_o)), mq);

    // R5: average saturation at both ends
    wake_auto(16383, -16384, 0);
    chk("R5 I saturates high", mi, 511);
    chk("R5 Q saturates low", mq, -512);
    settle_phase();
    run_smp(100, -100, "R2 after saturated cal");
    go_sleep();

    // R6/R3: user mode writes, clipping corners
    user_mode_i = 1'b1;
    host_wr(1'b0, 511);
    chk("R6 I write", int'($signed(ofs_i_o)), 511);
    host_wr(1'b1, -512);
    chk("R6 Q write", int'($signed(ofs_q_o)), -512);
    mi = 511; mq = -512;
    @(negedge clk);
    sleep_i = 1'b0;
    @(negedge clk);
    chk("R8 no cal in user mode", int'(cal_busy_o), 0);
    chk("R8 I kept at wake", int'($signed(ofs_i_o)), 511);
    settle_phase();
    run_smp(-16384, 16383, "R3 clip");
    chk("R3 I clipped low", int'($signed(out_i_o)), -16384);
    chk("R3 Q clipped high", int'($signed(out_q_o)), 16383);
    run_smp(16383, -16384, "R3 no clip");
    for (int k = 0; k < 20; k++) run_smp(rnd15(), rnd15(), "R2 user random");

    // R8: user offsets survive sleep
    host_wr(1'b0, -200);
    host_wr(1'b1, 137);
    mi = -200; mq = 137;
    go_sleep();
    repeat (5) @(negedge clk);
    @(negedge clk);
    sleep_i = 1'b0;
    @(negedge clk);
    chk("R8 busy stays low", int'(cal_busy_o), 0);
    chk("R8 I retained", int'($signed(ofs_i_o)), -200);
    chk("R8 Q retained", int'($signed(ofs_q_o)), 137);
    settle_phase();
    run_smp(0, 0, "R8 first output");
    for (int k = 0; k < 10; k++) run_smp(rnd15(), rnd15(), "R2 retained random");

    // R9: strobe is a single-cycle pulse
    @(negedge clk);
    chk("R9 valid one cycle", int'(out_valid_o), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule